// File: doc/BRIEF.md
# Interrupt presentation controller

This unit sits between a source controller and one processor. It holds at most one pending interrupt and drives the interrupt line of that processor. Its state has four parts. A 32-bit presentation word holds the current processor priority in bits 31:24 and the pending source number in bits 23:0. A pending-priority register sits beside it, and a software-interrupt priority register is the third part. An owner flag records whether the pending entry came from the source controller.

The source controller offers requests, each with a source number and a priority. The unit takes a request or bounces it back on the reject output. A taken request can displace a less favoured entry that is already pending. The processor side issues one operation per cycle: accept, poll, priority write, software-interrupt priority write, or end of interrupt. The unit answers with end-of-interrupt and resend pulses to the source side. A smaller priority value is more favoured, and 0xFF means none or masked. Source number 2 is reserved for the inter-processor interrupt made from the software-interrupt priority.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the presentation word is 0, the software-interrupt priority is 0xFF, the interrupt line is low and no pulse output is active.
- R2: A request whose priority is greater than or equal to the current processor priority (bits 31:24) is rejected: one cycle later the reject pulse carries its source number and the word is unchanged.
- R3: A request whose priority is not more favoured than a pending one (pending priority less than or equal to it) is rejected and the pending entry stays.
- R4: A request that is not rejected latches its source into bits 23:0 and raises the line. If another entry from the source controller was pending, that entry's source number goes out on the reject pulse in the same cycle.
- R5: Accept (op code 1) leaves the word visible on rd_data in the cycle it is issued. In the next cycle the current priority equals the old pending priority, the source number is 0 and the line is low.
- R6: A software-interrupt priority write (op code 4, value in op_data bits 7:0) that is below the current priority and more favoured than any pending entry loads source 2 and raises the line. A pending entry from the source controller is rejected.
- R7: A software-interrupt priority write does not change the pending entry when that entry's priority is less than or equal to the new value, or when the value is not below the current priority.
- R8: A priority write (op code 3, value in op_data bits 7:0) that lowers the current priority to a value at or below the pending priority clears the pending entry, lowers the line and rejects the entry to its source.
- R9: A priority write that does not lower the current priority and finds nothing pending emits a resend pulse. A write that finds an entry pending, or that lowers the priority while staying above the pending priority, keeps the entry.
- R10: End of interrupt (op code 5) loads the current priority from op_data bits 31:24 and sends bits 23:0 out on the end-of-interrupt pulse. If nothing is pending it also resends, and before that it makes the inter-processor interrupt if the software-interrupt priority is below the new current priority.
- R11: Poll (op code 2) changes nothing. req_ready is low whenever an operation is presented, and a request offered in that cycle is neither taken nor rejected.
- R12: Reject, end-of-interrupt and resend outputs are pulses one cycle wide, registered one clock after the causing input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request from the source controller |
| req_src | input | 24 | Source number of the request |
| req_prio | input | 8 | Priority of the request |
| req_ready | output | 1 | Request is considered this cycle |
| op_valid | input | 1 | Processor operation present |
| op_code | input | 3 | 1 accept, 2 poll, 3 priority write, 4 software-interrupt priority write, 5 end of interrupt |
| op_data | input | 32 | Operand of the operation |
| rd_data | output | 32 | Presentation word: priority 31:24, source 23:0 |
| mfrr_out | output | 8 | Software-interrupt priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse |
| rej_src | output | 24 | Source number being rejected |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_src | output | 24 | Source number ending |
| resend_valid | output | 1 | Resend request pulse |

## Verification
Every result is due exactly one clock after the edge that samples its stimulus. State, line and pulse registers all load on that one edge, so nothing is due two cycles later. The bench drives inputs on the falling edge and checks one time unit after the next rising edge. One-cycle pulse width is confirmed by an idle cycle after a reject. The accept read-back is checked in the cycle before the accept edge.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ACCEPT = 3'd1,
    OP_POLL   = 3'd2,
    OP_CPPR   = 3'd3,
    OP_MFRR   = 3'd4,
    OP_EOI    = 3'd5
  } ipu_op_e;
endpackage

// File: rtl/ipu_next.sv
module ipu_next
  import ipu_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = SRC_W + PRIO_W
) (
  input  logic [PRIO_W-1:0] cur_cppr,
  input  logic [SRC_W-1:0]  cur_src,
  input  logic [PRIO_W-1:0] cur_pend,
  input  logic [PRIO_W-1:0] cur_mfrr,
  input  logic              cur_own,
  input  logic              cur_irq,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [WORD_W-1:0] op_data,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  output logic [PRIO_W-1:0] nx_cppr,
  output logic [SRC_W-1:0]  nx_src,
  output logic [PRIO_W-1:0] nx_pend,
  output logic [PRIO_W-1:0] nx_mfrr,
  output logic              nx_own,
  output logic              nx_irq,
  output logic              nx_rej,
  output logic [SRC_W-1:0]  nx_rej_src,
  output logic              nx_eoi,
  output logic [SRC_W-1:0]  nx_eoi_src,
  output logic              nx_resend
);
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  logic          ipi_try;
  logic          busy;
  logic          lowered;
  ipu_op_e       op;

  assign op = ipu_op_e'(op_code);

  always_comb begin
    nx_cppr    = cur_cppr;
    nx_src     = cur_src;
    nx_pend    = cur_pend;
    nx_mfrr    = cur_mfrr;
    nx_own     = cur_own;
    nx_irq     = cur_irq;
    nx_rej     = 1'b0;
    nx_rej_src = '0;
    nx_eoi     = 1'b0;
    nx_eoi_src = '0;
    nx_resend  = 1'b0;
    ipi_try    = 1'b0;
    busy       = 1'b0;
    lowered    = 1'b0;
    if (op_valid) begin
      case (op)
        OP_ACCEPT: begin
          nx_cppr = cur_pend;
          nx_src  = '0;
          nx_pend = PRIO_NONE;
          nx_own  = 1'b0;
          nx_irq  = 1'b0;
        end
        OP_MFRR: begin
          nx_mfrr = op_data[PRIO_W-1:0];
          ipi_try = (op_data[PRIO_W-1:0] < cur_cppr);
        end
        OP_CPPR: begin
          nx_cppr = op_data[PRIO_W-1:0];
          lowered = (op_data[PRIO_W-1:0] < cur_cppr);
          if (lowered) begin
            if ((cur_src != '0) && (nx_cppr <= cur_pend)) begin
              nx_src  = '0;
              nx_pend = PRIO_NONE;
              nx_irq  = 1'b0;
              nx_own  = 1'b0;
              if (cur_own) begin
                nx_rej     = 1'b1;
                nx_rej_src = cur_src;
              end
            end
          end else if (cur_src == '0) begin
            nx_resend = 1'b1;
            ipi_try   = (cur_mfrr < nx_cppr);
          end
        end
        OP_EOI: begin
          nx_cppr    = op_data[WORD_W-1 -: PRIO_W];
          nx_eoi     = 1'b1;
          nx_eoi_src = op_data[SRC_W-1:0];
          if (cur_src == '0) begin
            nx_resend = 1'b1;
            ipi_try   = (cur_mfrr < nx_cppr);
          end
        end
        default: ;
      endcase
    end else if (req_valid) begin
      busy = (cur_src != '0) && (cur_pend <= req_prio);
      if ((req_prio >= cur_cppr) || busy) begin
        nx_rej     = 1'b1;
        nx_rej_src = req_src;
      end else begin
        if ((cur_src != '0) && cur_own) begin
          nx_rej     = 1'b1;
          nx_rej_src = cur_src;
        end
        nx_src  = req_src;
        nx_pend = req_prio;
        nx_own  = 1'b1;
        nx_irq  = 1'b1;
      end
    end
    // inter-processor interrupt check, applied to the already updated state
    if (ipi_try && !((nx_src != '0) && (nx_pend <= nx_mfrr))) begin
      if ((nx_src != '0) && nx_own) begin
        nx_rej     = 1'b1;
        nx_rej_src = nx_src;
      end
      nx_src  = IPI_NUM;
      nx_pend = nx_mfrr;
      nx_own  = 1'b0;
      nx_irq  = 1'b1;
    end
  end
endmodule

// File: rtl/ipu_regs.sv
module ipu_regs #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [PRIO_W-1:0] nx_cppr,
  input  logic [SRC_W-1:0]  nx_src,
  input  logic [PRIO_W-1:0] nx_pend,
  input  logic [PRIO_W-1:0] nx_mfrr,
  input  logic              nx_own,
  input  logic              nx_irq,
  input  logic              nx_rej,
  input  logic [SRC_W-1:0]  nx_rej_src,
  input  logic              nx_eoi,
  input  logic [SRC_W-1:0]  nx_eoi_src,
  input  logic              nx_resend,
  output logic [PRIO_W-1:0] cppr_q,
  output logic [SRC_W-1:0]  src_q,
  output logic [PRIO_W-1:0] pend_q,
  output logic [PRIO_W-1:0] mfrr_q,
  output logic              own_q,
  output logic              irq_q,
  output logic              rej_q,
  output logic [SRC_W-1:0]  rej_src_q,
  output logic              eoi_q,
  output logic [SRC_W-1:0]  eoi_src_q,
  output logic              resend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr_q <= '0;
      src_q  <= '0;
      pend_q <= '1;
      mfrr_q <= '1;
      own_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (upd_en) begin
      cppr_q <= nx_cppr;
      src_q  <= nx_src;
      pend_q <= nx_pend;
      mfrr_q <= nx_mfrr;
      own_q  <= nx_own;
      irq_q  <= nx_irq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_q     <= 1'b0;
      rej_src_q <= '0;
      eoi_q     <= 1'b0;
      eoi_src_q <= '0;
      resend_q  <= 1'b0;
    end else begin
      rej_q     <= nx_rej;
      rej_src_q <= nx_rej_src;
      eoi_q     <= nx_eoi;
      eoi_src_q <= nx_eoi_src;
      resend_q  <= nx_resend;
    end
  end
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit
  import ipu_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2,
  localparam int WORD_W = SRC_W + PRIO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [PRIO_W-1:0] req_prio,
  output logic              req_ready,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [WORD_W-1:0] op_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [PRIO_W-1:0] mfrr_out,
  output logic              irq_out,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_src,
  output logic              resend_valid
);
  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q, nx_cppr, nx_pend, nx_mfrr;
  logic [SRC_W-1:0]  src_q, nx_src, nx_rej_src, nx_eoi_src;
  logic              own_q, nx_own, nx_irq, nx_rej, nx_eoi, nx_resend;

  ipu_next #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_next (
    .cur_cppr(cppr_q), .cur_src(src_q), .cur_pend(pend_q), .cur_mfrr(mfrr_q),
    .cur_own(own_q), .cur_irq(irq_out),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .req_valid(req_valid), .req_src(req_src), .req_prio(req_prio),
    .nx_cppr(nx_cppr), .nx_src(nx_src), .nx_pend(nx_pend), .nx_mfrr(nx_mfrr),
    .nx_own(nx_own), .nx_irq(nx_irq), .nx_rej(nx_rej), .nx_rej_src(nx_rej_src),
    .nx_eoi(nx_eoi), .nx_eoi_src(nx_eoi_src), .nx_resend(nx_resend)
  );

  ipu_regs #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .upd_en(op_valid | req_valid),
    .nx_cppr(nx_cppr), .nx_src(nx_src), .nx_pend(nx_pend), .nx_mfrr(nx_mfrr),
    .nx_own(nx_own), .nx_irq(nx_irq), .nx_rej(nx_rej), .nx_rej_src(nx_rej_src),
    .nx_eoi(nx_eoi), .nx_eoi_src(nx_eoi_src), .nx_resend(nx_resend),
    .cppr_q(cppr_q), .src_q(src_q), .pend_q(pend_q), .mfrr_q(mfrr_q),
    .own_q(own_q), .irq_q(irq_out), .rej_q(rej_valid), .rej_src_q(rej_src),
    .eoi_q(eoi_valid), .eoi_src_q(eoi_src), .resend_q(resend_valid)
  );

  assign rd_data   = {cppr_q, src_q};
  assign mfrr_out  = mfrr_q;
  assign req_ready = ~op_valid;

  // line follows presence of a pending entry
  p_line_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (src_q != '0));

  // an empty slot always carries the "none" priority
  p_empty_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == '0) |-> (pend_q == '1));

  p_low_prio_bounce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !op_valid && (req_prio >= cppr_q))
      |=> (rej_valid && (rej_src == $past(req_src))));

  p_accept_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 3'd1))
      |=> ((src_q == '0) && !irq_out && (cppr_q == $past(pend_q))));

  p_eoi_forward_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 3'd5))
      |=> (eoi_valid && (eoi_src == $past(op_data[SRC_W-1:0]))));
endmodule

// File: tb/sim_intr_present_unit.sv
module sim_intr_present_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] data;
    logic        rv;
    logic [23:0] src;
    logic [7:0]  prio;
    logic [31:0] xw;
    logic        irq;
    logic        rej;
    logic [23:0] rsrc;
    logic        eoi;
    logic [23:0] esrc;
    logic        rsd;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h0,        1'b1, 24'h10, 8'h05, 32'h00000000, 1'b0, 1'b1, 24'h10, 1'b0, 24'h0, 1'b0}, // R2
    '{3'd3, 32'hFF,       1'b0, 24'h0,  8'h00, 32'hFF000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0, 1'b1}, // R9
    '{3'd0, 32'h0,        1'b1, 24'h10, 8'h05, 32'hFF000010, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0}, // R4
    '{3'd0, 32'h0,        1'b1, 24'h20, 8'h05, 32'hFF000010, 1'b1, 1'b1, 24'h20, 1'b0, 24'h0, 1'b0}, // R3
    '{3'd0, 32'h0,        1'b1, 24'h20, 8'h03, 32'hFF000020, 1'b1, 1'b1, 24'h10, 1'b0, 24'h0, 1'b0}, // R4
    '{3'd4, 32'h04,       1'b0, 24'h0,  8'h00, 32'hFF000020, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0}, // R7
    '{3'd4, 32'h01,       1'b0, 24'h0,  8'h00, 32'hFF000002, 1'b1, 1'b1, 24'h20, 1'b0, 24'h0, 1'b0}, // R6
    '{3'd1, 32'h0,        1'b0, 24'h0,  8'h00, 32'h01000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0}, // R5
    '{3'd5, 32'hFF000002, 1'b0, 24'h0,  8'h00, 32'hFF000002, 1'b1, 1'b0, 24'h0,  1'b1, 24'h2, 1'b1}, // R10
    '{3'd4, 32'hFF,       1'b0, 24'h0,  8'h00, 32'hFF000002, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0}, // R7
    '{3'd1, 32'h0,        1'b0, 24'h0,  8'h00, 32'h01000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0}, // R5
    '{3'd5, 32'h05000000, 1'b0, 24'h0,  8'h00, 32'h05000000, 1'b0, 1'b0, 24'h0,  1'b1, 24'h0, 1'b1}, // R10
    '{3'd0, 32'h0,        1'b1, 24'h30, 8'h04, 32'h05000030, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0}, // R4
    '{3'd3, 32'h04,       1'b0, 24'h0,  8'h00, 32'h04000000, 1'b0, 1'b1, 24'h30, 1'b0, 24'h0, 1'b0}, // R8
    '{3'd3, 32'h06,       1'b0, 24'h0,  8'h00, 32'h06000000, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0, 1'b1}, // R9
    '{3'd0, 32'h0,        1'b1, 24'h40, 8'h02, 32'h06000040, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0}, // R4
    '{3'd3, 32'h03,       1'b0, 24'h0,  8'h00, 32'h03000040, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0}, // R9
    '{3'd3, 32'h07,       1'b0, 24'h0,  8'h00, 32'h07000040, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0}, // R9
    '{3'd2, 32'h0,        1'b0, 24'h0,  8'h00, 32'h07000040, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0, 1'b0}  // R11
  };
  localparam string VTAG [NV] = '{"R2","R9","R4","R3","R4","R7","R6","R5","R10","R7",
                                  "R5","R10","R4","R8","R9","R4","R9","R9","R11"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [23:0] req_src = '0;
  logic [7:0]  req_prio = '0;
  logic        req_ready;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] op_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  mfrr_out;
  logic        irq_out, rej_valid, eoi_valid, resend_valid;
  logic [23:0] rej_src, eoi_src;
  int          n_chk = 0;
  int          n_err = 0;
  int          cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_present_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_prio(req_prio), .req_ready(req_ready), .op_valid(op_valid),
    .op_code(op_code), .op_data(op_data), .rd_data(rd_data), .mfrr_out(mfrr_out),
    .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_valid(resend_valid)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [31:0] d,
                       input logic rv, input logic [23:0] s, input logic [7:0] p);
    @(negedge clk);
    op_valid  = (op != 3'd0);
    op_code   = op;
    op_data   = d;
    req_valid = rv;
    req_src   = s;
    req_prio  = p;
    @(posedge clk);
    #1;
  endtask

  task automatic check_reset();
    check("R1", "word", rd_data, 32'h0);
    check("R1", "mfrr", {24'h0, mfrr_out}, 32'hFF);
    check("R1", "line", {31'h0, irq_out}, 32'h0);
    check("R1", "pulses", {29'h0, rej_valid, eoi_valid, resend_valid}, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].data, VEC[i].rv, VEC[i].src, VEC[i].prio);
      check(VTAG[i], "word", rd_data, VEC[i].xw);
      check(VTAG[i], "line", {31'h0, irq_out}, {31'h0, VEC[i].irq});
      check(VTAG[i], "reject", {7'h0, rej_valid, rej_src}, {7'h0, VEC[i].rej, VEC[i].rsrc});
      check(VTAG[i], "eoi", {7'h0, eoi_valid, eoi_src}, {7'h0, VEC[i].eoi, VEC[i].esrc});
      check("R12", "resend", {31'h0, resend_valid}, {31'h0, VEC[i].rsd});
    end
    check("R6", "mfrr readback", {24'h0, mfrr_out}, 32'hFF);

    // R11: request during an operation is held off
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd2; req_valid = 1'b1; req_src = 24'h50; req_prio = 8'h00;
    #1;
    check("R11", "req_ready", {31'h0, req_ready}, 32'h0);
    @(posedge clk); #1;
    check("R11", "word kept", rd_data, 32'h07000040);
    check("R11", "no reject", {31'h0, rej_valid}, 32'h0);

    // R12: reject pulse lasts one cycle
    drive(3'd0, 32'h0, 1'b1, 24'h60, 8'h09);
    check("R12", "reject pulse", {7'h0, rej_valid, rej_src}, {8'h01, 24'h60});
    drive(3'd0, 32'h0, 1'b0, 24'h0, 8'h0);
    check("R12", "pulse gone", {31'h0, rej_valid}, 32'h0);

    // R6: IPI with a source-controller entry pending and a lower CPPR
    drive(3'd4, 32'h01, 1'b0, 24'h0, 8'h0);
    check("R6", "ipi word", rd_data, 32'h07000002);
    check("R6", "ipi reject", {7'h0, rej_valid, rej_src}, {8'h01, 24'h40});
    check("R6", "mfrr", {24'h0, mfrr_out}, 32'h01);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    drive(3'd0, 32'h0, 1'b0, 24'h0, 8'h0);
    check("R1", "after release", rd_data, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule